// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block drives and samples up to six banks of general-purpose pins, 32 pins per bank, with the last bank allowed to be narrower. Software reaches it through a simple synchronous register port. The port has an address, a write strobe, write data and combinational read data. Each bank holds its own output, direction, edge-enable, edge-status and interrupt-mask state. Pins are driven through atomic set and clear words, so a write never has to read, modify and write the output state.

Pad inputs pass through a two-stage synchroniser. Edge detection compares the synchronised value with its value one cycle earlier. A qualifying edge latches a sticky status bit, which software clears by writing a 1 to it. A single interrupt line is raised whenever any status bit is set while its mask bit is on, in any bank.

The register map is interleaved. Registers of the same kind for neighbouring banks sit 4 bytes apart. Banks 3 and above live in a second window that starts at 0x100.

Top module: `pinbank_gpio`

## Requirements
- R1: For banks 0..2, the register kinds sit at these offsets plus 4×bank: level 0x00, direction 0x0C, set 0x18, clear 0x24, rise-enable 0x30, fall-enable 0x3C, edge-status 0x48, irq-mask 0x9C.
- R2: Banks 3..5 use the same kind offsets, added to a base of 0x100 + 4×(bank−3). For example, the set register of bank 4 is at 0x11C.
- R3: Writing the set register drives high every output bit written as 1. Writing the clear register drives every such bit low. Bits written as 0 keep their value. pin_out changes on the clock edge that takes the write.
- R4: The level register returns the synchronised pin state. A change on pin_in becomes visible on the second rising clock edge after it, and not on the first.
- R5: A direction bit of 1 asserts pin_oe for that pin, and 0 releases it. The direction register reads back as written.
- R6: For the global pin indices INV_FIRST..INV_LAST (default 86..89, which are bank 2 bits 22..25), the direction polarity is inverted. On those pins a stored 0 asserts pin_oe, and their stored reset value is 1.
- R7: An edge-status bit sets on a rising edge of its synchronised pin when rise-enable is on, and on a falling edge when fall-enable is on. With both enables on, both edges set it. An edge with its enable off has no effect.
- R8: Writing 1 to an edge-status bit clears it. Writing 0 leaves it unchanged.
- R9: When a qualifying edge and a write-1-to-clear of the same bit land on the same clock edge, the bit stays set.
- R10: irq is high exactly when some bank has an edge-status bit set with its irq-mask bit at 1. The irq-mask register resets to 0.
- R11: The last bank holds LAST_BANK_PINS pins (default 24). Its bits from LAST_BANK_PINS to 31 read as 0 in every register, and writes to them have no effect.
- R12: Reads of the set and clear addresses return 0, and so do reads of any address that maps to no register.
- R13: After reset, pin_out and pin_oe are all 0, the edge-status and enable registers are 0, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 9 | Register byte address |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | NUM_PINS (184) | Pad input levels |
| pin_out | output | NUM_PINS (184) | Output drive levels |
| pin_oe | output | NUM_PINS (184) | Output enables, 1 = drive |
| irq | output | 1 | Combined masked edge interrupt |

## Verification
The sharpest corner case is an edge that arrives on the same clock edge as a write-1-to-clear of its bit. A design that gives the clear priority silently loses that event, and the status read afterwards comes back 0. The bench also checks the interleaved addressing in both windows. A decoder that gets the bank stride or the 0x100 window wrong writes the wrong bank, and the expected pin never moves.

Three further cases are covered:
- Level latency is probed one cycle early. A design with a single synchroniser stage shows the new level too soon.
- The inverted-direction pins and the narrow last bank are checked. An implementation that ignores either drives the wrong enables, or reads back bits that do not exist.
- A pending but masked status bit must leave irq low. An interrupt that ignores the mask is caught by that check.

// File: rtl/pinbank_pkg.sv
// Package: shared address map constants, register kinds and helpers for
// the banked GPIO controller. Assumes at most six banks (9-bit address).
package pinbank_pkg;

    localparam int ADDR_W = 9;
    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        RK_LEVEL,
        RK_DIR,
        RK_SET,
        RK_CLR,
        RK_RISE,
        RK_FALL,
        RK_STAT,
        RK_MASK,
        RK_NONE
    } reg_kind_e;

    // Base byte address of a bank: low window for banks 0..2, 0x100 window above.
    function automatic logic [ADDR_W-1:0] bank_base(input int b);
        if (b < 3) return ADDR_W'(b * 4);
        return ADDR_W'(256 + (b - 3) * 4);
    endfunction

    // Register kind selected by an offset from a bank base.
    function automatic reg_kind_e kind_of(input logic [ADDR_W-1:0] off);
        case (off)
            9'h000:  return RK_LEVEL;
            9'h00C:  return RK_DIR;
            9'h018:  return RK_SET;
            9'h024:  return RK_CLR;
            9'h030:  return RK_RISE;
            9'h03C:  return RK_FALL;
            9'h048:  return RK_STAT;
            9'h09C:  return RK_MASK;
            default: return RK_NONE;
        endcase
    endfunction

    // Per-bank mask of pins whose direction polarity is inverted.
    function automatic logic [WORD_W-1:0] inv_mask(input int b, input int lo, input int hi);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = ((b * WORD_W + i) >= lo) && ((b * WORD_W + i) <= hi);
        end
        return m;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
// Module: two-flop input synchroniser plus one history stage.
// Assumes pin_in is asynchronous to clk; q is the synchronised level and
// q_prev the same value one cycle earlier, used for edge detection.
module pinbank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);

    logic [W-1:0] meta_q;

    // Purpose: shift pad levels through metastability and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
            q_prev <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
            q_prev <= q;
        end
    end

endmodule

// File: rtl/pinbank_bank.sv
// Module: one bank of NPIN pins. It decodes its own registers from the
// shared bus, holds output/direction/enable/status/mask state, captures
// edges and reports a masked interrupt request. Assumes lvl/lvl_prev come
// from a synchroniser; read data is combinational.
module pinbank_bank
    import pinbank_pkg::*;
#(
    parameter int                BANK_IDX = 0,
    parameter int                NPIN     = 32,
    parameter logic [WORD_W-1:0] INV_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPIN-1:0]   wdata,
    input  logic [NPIN-1:0]   lvl,
    input  logic [NPIN-1:0]   lvl_prev,
    output logic [NPIN-1:0]   rdata,
    output logic [NPIN-1:0]   out_q,
    output logic [NPIN-1:0]   oe,
    output logic [NPIN-1:0]   stat_q,
    output logic              irq_req
);

    localparam logic [ADDR_W-1:0] BASE    = bank_base(BANK_IDX);
    localparam logic [NPIN-1:0]   INV_BITS = INV_MASK[NPIN-1:0];

    reg_kind_e       kind;
    logic [NPIN-1:0] dir_q, rise_q, fall_q, mask_q;
    logic [NPIN-1:0] evt, clr_bits;

    // Purpose: identify which of this bank's registers the address selects.
    always_comb kind = kind_of(bus_addr - BASE);

    // Purpose: output latch driven by atomic set and clear words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (bus_we && kind == RK_SET) begin
            out_q <= out_q | wdata;
        end else if (bus_we && kind == RK_CLR) begin
            out_q <= out_q & ~wdata;
        end
    end

    // Purpose: configuration registers (direction, edge enables, mask).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= INV_BITS;
            rise_q <= '0;
            fall_q <= '0;
            mask_q <= '0;
        end else if (bus_we) begin
            if (kind == RK_DIR)  dir_q  <= wdata;
            if (kind == RK_RISE) rise_q <= wdata;
            if (kind == RK_FALL) fall_q <= wdata;
            if (kind == RK_MASK) mask_q <= wdata;
        end
    end

    // Purpose: qualify synchronised transitions with the edge enables.
    always_comb evt = (lvl & ~lvl_prev & rise_q) | (~lvl & lvl_prev & fall_q);

    // Purpose: write-1-to-clear pattern for the status register.
    always_comb clr_bits = (bus_we && kind == RK_STAT) ? wdata : '0;

    // Purpose: sticky edge status; a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_bits) | evt;
        end
    end

    // Purpose: effective output enable after polarity correction.
    always_comb oe = dir_q ^ INV_BITS;

    // Purpose: masked interrupt request of this bank.
    always_comb irq_req = |(stat_q & mask_q);

    // Purpose: read mux; write-only and unmapped kinds read zero.
    always_comb begin
        case (kind)
            RK_LEVEL: rdata = lvl;
            RK_DIR:   rdata = dir_q;
            RK_RISE:  rdata = rise_q;
            RK_FALL:  rdata = fall_q;
            RK_STAT:  rdata = stat_q;
            RK_MASK:  rdata = mask_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/pinbank_gpio.sv
// Module: top of the banked GPIO controller. It synchronises all pads,
// instantiates one bank per NUM_BANKS, combines read data and interrupt
// requests. Assumes 1 <= NUM_BANKS <= 6 and 1 <= LAST_BANK_PINS <= 32.
module pinbank_gpio
    import pinbank_pkg::*;
#(
    parameter int NUM_BANKS      = 6,
    parameter int LAST_BANK_PINS = 24,
    parameter int INV_FIRST      = 86,
    parameter int INV_LAST       = 89,
    localparam int NUM_PINS      = (NUM_BANKS - 1) * WORD_W + LAST_BANK_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    logic [NUM_PINS-1:0] sync_q, sync_prev;
    logic [WORD_W-1:0]   rd_bank   [NUM_BANKS];
    logic [WORD_W-1:0]   stat_bank [NUM_BANKS];
    logic [NUM_BANKS-1:0] irq_bank;

    pinbank_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pin_in),
        .q      (sync_q),
        .q_prev (sync_prev)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int NB = (b == NUM_BANKS - 1) ? LAST_BANK_PINS : WORD_W;
        localparam int LO = b * WORD_W;

        logic [NB-1:0] rd_n, out_n, oe_n, stat_n;

        pinbank_bank #(
            .BANK_IDX (b),
            .NPIN     (NB),
            .INV_MASK (inv_mask(b, INV_FIRST, INV_LAST))
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .bus_addr (bus_addr),
            .bus_we   (bus_we),
            .wdata    (bus_wdata[NB-1:0]),
            .lvl      (sync_q[LO+:NB]),
            .lvl_prev (sync_prev[LO+:NB]),
            .rdata    (rd_n),
            .out_q    (out_n),
            .oe       (oe_n),
            .stat_q   (stat_n),
            .irq_req  (irq_bank[b])
        );

        // Purpose: widen bank-local vectors to bus width with zero padding.
        always_comb begin
            rd_bank[b]          = '0;
            rd_bank[b][NB-1:0]  = rd_n;
            stat_bank[b]        = '0;
            stat_bank[b][NB-1:0] = stat_n;
        end

        assign pin_out[LO+:NB] = out_n;
        assign pin_oe[LO+:NB]  = oe_n;
    end

    // Purpose: OR the bank read words; at most one bank decodes an address.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) bus_rdata = bus_rdata | rd_bank[b];
    end

    // Purpose: single interrupt line from all banks.
    always_comb irq = |irq_bank;

endmodule

// File: rtl/pinbank_chk.sv
// Module: protocol checker bound to pinbank_gpio. Observes bus writes,
// pin outputs, bank 0 status and the interrupt line.
module pinbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [8:0]  bus_addr,
    input logic        bus_we,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [7:0]  pout_lo,
    input logic [31:0] stat0,
    input logic        irq
);

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 9'h018 && bus_wdata[0]) |=> pout_lo[0]); // R3

    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 9'h024 && bus_wdata[0]) |=> !pout_lo[0]); // R3

    AST_ZERO_WORD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == 9'h018 || bus_addr == 9'h024) && bus_wdata[7:0] == 8'h00)
        |=> $stable(pout_lo)); // R3

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ((stat0 & $past(stat0)) == $past(stat0))); // R8

    AST_WRITE_ONLY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 9'h018 || bus_addr == 9'h024) |-> bus_rdata == 32'h0); // R12

    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> !irq); // R13

endmodule

bind pinbank_gpio pinbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pout_lo   (pin_out[7:0]),
    .stat0     (stat_bank[0]),
    .irq       (irq)
);

// File: tb/test_pinbank_gpio.sv
module test_pinbank_gpio;

    localparam int NP = 184;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [8:0]    bus_addr = '0;
    logic          bus_we = 0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pinbank_gpio i_pinbank_gpio (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R13 pin_out", {31'b0, |pin_out}, 32'h0);
        check("R13 pin_oe", {31'b0, |pin_oe}, 32'h0);
        check("R13 irq", {31'b0, irq}, 32'h0);
        rd(9'h00C, v); check("R13 dir bank0", v, 32'h0);
        rd(9'h014, v); check("R6 dir reset bank2", v, 32'h03C0_0000);
        rd(9'h048, v); check("R13 status bank0", v, 32'h0);
        rd(9'h09C, v); check("R10 mask reset", v, 32'h0);
    endtask

    task automatic t_setclr();
        wr(9'h018, 32'hA5);
        check("R3 set", {24'b0, pin_out[7:0]}, 32'hA5);
        wr(9'h024, 32'h05);
        check("R3 clear", {24'b0, pin_out[7:0]}, 32'hA0);
        wr(9'h018, 32'h00);
        check("R3 zero word keeps", {24'b0, pin_out[7:0]}, 32'hA0);
        wr(9'h01C, 32'h8);
        check("R1 bank1 set", {31'b0, pin_out[35]}, 32'h1);
        wr(9'h11C, 32'h1);
        check("R2 bank4 set", {31'b0, pin_out[128]}, 32'h1);
        check("R2 bank3 untouched", pin_out[127:96], 32'h0);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        wr(9'h00C, 32'hF);
        check("R5 oe", {28'b0, pin_oe[3:0]}, 32'hF);
        rd(9'h00C, v); check("R5 readback", v, 32'hF);
        wr(9'h014, 32'h0);
        check("R6 inverted oe", pin_oe[95:64], 32'h03C0_0000);
    endtask

    task automatic t_level();
        @(negedge clk); pin_in[40] = 1;
        @(negedge clk); bus_addr = 9'h004;
        #1 check("R4 not after one edge", bus_rdata, 32'h0);
        @(negedge clk);
        #1 check("R4 after two edges", bus_rdata, 32'h100);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(9'h030, 32'h5);
        wr(9'h03C, 32'h6);
        @(negedge clk); pin_in[1:0] = 2'b11; settle();
        rd(9'h048, v); check("R7 rise only where enabled", v, 32'h1);
        @(negedge clk); pin_in[1:0] = 2'b00; settle();
        rd(9'h048, v); check("R7 fall", v, 32'h3);
        @(negedge clk); pin_in[2] = 1; settle();
        @(negedge clk); pin_in[2] = 0; settle();
        rd(9'h048, v); check("R7 both edges", v, 32'h7);
        check("R10 masked status no irq", {31'b0, irq}, 32'h0);
        wr(9'h048, 32'h0);
        rd(9'h048, v); check("R8 zero no effect", v, 32'h7);
        wr(9'h048, 32'h1);
        rd(9'h048, v); check("R8 clear one bit", v, 32'h6);
        wr(9'h048, 32'hFFFF_FFFF);
        rd(9'h048, v); check("R8 clear all", v, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        wr(9'h030, 32'h10);
        wr(9'h03C, 32'h10);
        @(negedge clk); pin_in[4] = 1; settle();
        rd(9'h048, v); check("R7 bit4 set", v, 32'h10);
        @(negedge clk); pin_in[4] = 0;
        @(negedge clk);
        wr(9'h048, 32'h10);
        rd(9'h048, v); check("R9 edge beats clear", v, 32'h10);
        wr(9'h048, 32'h10);
        rd(9'h048, v); check("R8 later clear", v, 32'h0);
    endtask

    task automatic t_irq();
        wr(9'h1A4, 32'h4);
        wr(9'h138, 32'h4);
        @(negedge clk); pin_in[162] = 1; settle();
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        wr(9'h150, 32'h4);
        check("R10 irq dropped", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_partial();
        logic [31:0] v;
        wr(9'h120, 32'hFFFF_FFFF);
        check("R11 last bank outputs", {8'b0, pin_out[183:160]}, 32'h00FF_FFFF);
        wr(9'h114, 32'hFFFF_FFFF);
        rd(9'h114, v); check("R11 dir width", v, 32'h00FF_FFFF);
        @(negedge clk); pin_in[183:160] = '1; settle();
        rd(9'h108, v); check("R11 level width", v, 32'h00FF_FFFF);
    endtask

    task automatic t_rozero();
        logic [31:0] v;
        rd(9'h018, v); check("R12 set reads 0", v, 32'h0);
        rd(9'h12C, v); check("R12 clear reads 0", v, 32'h0);
        rd(9'h054, v); check("R12 unmapped", v, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_setclr();
        t_dir();
        t_level();
        t_edge();
        t_race();
        t_irq();
        t_partial();
        t_rozero();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule